// File: doc/BRIEF.md
# Low-Frequency Oscillator Control Register

This block is one 32-bit control and status register for an optional external 32.768 kHz oscillator. It also picks the timebase that drives the real-time clock and the power-management logic. Software reaches it over a simple register bus with an address, a write strobe, write data and combinational read data. Setting the enable bit turns the oscillator on. The enable bit can only be set, and only a hardware reset clears it. A stabilization counter then runs for a parameterized number of cycles and raises a ready flag, which software cannot write and which stays set until reset.

The block runs on the fast reference clock of nominally 3.6864 MHz. It does not switch clocks. It produces a one-cycle timebase tick enable instead. While the ready flag is clear, the tick comes from the reference divided by 112. Once the ready flag is set, the tick comes from each synchronized rising edge of the low-frequency input. The ready flag also qualifies a request to power down the fast oscillator in sleep. The qualified request is forced low until the low-frequency source is ready.

Top module: `lfosc_ctrl_reg`

## Requirements
- R1: After reset, the register at byte offset 0x8 reads 0. The tick, the low-frequency-select output and the qualified sleep output are all 0.
- R2: A write to offset 0x8 with bit 1 = 1 sets the enable bit, which reads back at bit 1 and drives `osc_en`. A later write with bit 1 = 0 leaves it set.
- R3: Bit 0 of offset 0x8 is the ready flag, and writes to bit 0 do not change it. It reads 1 exactly SETTLE_CYCLES clock cycles after the enable bit first reads 1, and it reads 0 in every cycle before that.
- R4: Once set, the enable bit and the ready flag stay set until hardware reset (`rst_n` low), which clears both.
- R5: Bits 31 to 2 of offset 0x8 always read 0, whatever value is written to them.
- R6: Reads from offsets 0x0, 0x4 and 0xC return 0. Writes to those offsets change no state.
- R7: While the ready flag is 0, `tb_tick` is a one-cycle pulse that repeats every DIV_RATIO (112) cycles, and the low-frequency input has no effect on it.
- R8: While the ready flag is 1, `tb_is_lf` is 1 and `tb_tick` pulses once for each rising edge of `lf_clk`. The pulse comes within three clock cycles of that edge.
- R9: `sleep_fast_off` equals `sleep_fast_off_req` while the ready flag is 1, and is 0 while the ready flag is 0.
- R10: `bus_rdata` is combinational in `bus_addr`, so it is valid in the same cycle that the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| lf_clk | input | 1 | Low-frequency oscillator output, asynchronous |
| sleep_fast_off_req | input | 1 | Request to power down the fast oscillator in sleep |
| osc_en | output | 1 | Enable for the low-frequency oscillator |
| tb_tick | output | 1 | One-cycle tick enable for the selected timebase |
| tb_is_lf | output | 1 | 1 when the timebase comes from the low-frequency source |
| sleep_fast_off | output | 1 | Sleep power-down request after qualification by the ready flag |

## Verification
The enable bit is visible on the bus one clock edge after the write strobe is sampled. The ready flag follows SETTLE_CYCLES edges after that, so the bench reads the register on the falling edge after every cycle of the window and expects the flag to change only on the last one. A divider tick appears every 112 cycles, so the bench times the gaps between ticks and counts the ticks in whole multiples of the period. The low-frequency tick trails the input edge by up to three edges, so the bench only counts ticks between sampled falling edges of the slow input. Read data and the qualified sleep output are combinational and are sampled one time step after the inputs change.

// File: rtl/lfosc_pkg.sv
package lfosc_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] CTRL_OFFSET = 4'h8;
  localparam int unsigned BIT_READY  = 0;
  localparam int unsigned BIT_ENABLE = 1;
endpackage

// File: rtl/lfosc_regfile.sv
module lfosc_regfile
  import lfosc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OFFSET = CTRL_OFFSET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready_i,
  output logic              en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic en_q, en_d;
  logic hit;
  logic unused_wbits;

  assign hit = (addr == OFFSET);
  assign unused_wbits = ^{wdata[DATA_W-1:BIT_ENABLE+1], wdata[BIT_READY]};

  // set-only enable
  always_comb begin
    en_d = en_q;
    if (wr_en && hit && wdata[BIT_ENABLE]) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[BIT_ENABLE] = en_q;
      rdata_o[BIT_READY]  = ready_i;
    end
  end

  assign en_o = en_q;

  assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  assert_ready_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready_i |-> en_q);
endmodule

// File: rtl/lfosc_settle_timer.sv
module lfosc_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 36864000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ready_q, ready_d;
  logic          counting;

  assign counting = en_i && !ready_q;

  always_comb begin
    cnt_d   = cnt_q;
    ready_d = ready_q;
    if (counting) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

  assign ready_o = ready_q;

  assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);
  assert_ready_after_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(cnt_q) == LAST));
  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SETTLE_CYCLES));
endmodule

// File: rtl/lfosc_tick_gen.sv
module lfosc_tick_gen #(
  parameter int unsigned DIV_RATIO   = 112,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lf_clk_i,
  input  logic use_lf_i,
  output logic tick_o
);
  localparam int unsigned DW = $clog2(DIV_RATIO);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_RATIO - 1);

  logic [DW-1:0]          div_q, div_d;
  logic                   div_pulse;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lf_prev_q;
  logic                   lf_pulse;
  logic                   tick_q, tick_d;

  // fast reference divider
  assign div_pulse = (div_q == DIV_LAST);
  always_comb div_d = div_pulse ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // low-frequency input synchronizer
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= lf_clk_i;
        else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lf_prev_q <= 1'b0;
    else        lf_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign lf_pulse = sync_q[SYNC_STAGES-1] && !lf_prev_q;

  always_comb tick_d = use_lf_i ? lf_pulse : div_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;

  assert_div_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= DIV_LAST);
  assert_tick_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/lfosc_ctrl_reg.sv
module lfosc_ctrl_reg
  import lfosc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 36864000,
  parameter int unsigned DIV_RATIO     = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lf_clk,
  input  logic              sleep_fast_off_req,
  output logic              osc_en,
  output logic              tb_tick,
  output logic              tb_is_lf,
  output logic              sleep_fast_off
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       en;
  logic       ready;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1] && rst_n;

  lfosc_regfile #(.OFFSET(CTRL_OFFSET)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .ready_i (ready),
    .en_o    (en),
    .rdata_o (bus_rdata)
  );

  lfosc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (en),
    .ready_o (ready)
  );

  lfosc_tick_gen #(.DIV_RATIO(DIV_RATIO), .SYNC_STAGES(2)) u_tick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lf_clk_i (lf_clk),
    .use_lf_i (ready),
    .tick_o   (tb_tick)
  );

  assign osc_en         = en;
  assign tb_is_lf       = ready;
  assign sleep_fast_off = sleep_fast_off_req && ready;

  assert_sleep_masked_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rdata[BIT_READY] && (bus_addr == CTRL_OFFSET) |-> !sleep_fast_off);
endmodule

// File: tb/lfosc_ctrl_reg_tb.sv
module lfosc_ctrl_reg_tb;
  localparam int unsigned SETTLE = 20;
  localparam int unsigned DIV    = 112;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lf_clk = 1'b0;
  logic        sleep_req = 1'b0;
  logic        osc_en, tb_tick, tb_is_lf, sleep_off;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #51 lf_clk = ~lf_clk;

  lfosc_ctrl_reg #(.SETTLE_CYCLES(SETTLE), .DIV_RATIO(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lf_clk(lf_clk),
    .sleep_fast_off_req(sleep_req), .osc_en(osc_en), .tb_tick(tb_tick),
    .tb_is_lf(tb_is_lf), .sleep_fast_off(sleep_off)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tb_tick);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n, cnt, falls;
    logic lf_last;

    // R1: reset state
    #1;
    check("R1 tick in reset", {31'b0, tb_tick}, 0);
    do_reset();
    bus_read(4'h8, rd);  check("R1 reg after reset", rd, 0);
    check("R1 is_lf", {31'b0, tb_is_lf}, 0);
    check("R1 osc_en", {31'b0, osc_en}, 0);

    // R9: masked while not ready
    sleep_req = 1'b1; #0.5;
    check("R9 sleep masked", {31'b0, sleep_off}, 0);
    sleep_req = 1'b0;

    // R3: ready bit not writable; R5: reserved bits ignored
    bus_write(4'h8, 32'h0000_0001);
    bus_read(4'h8, rd);  check("R3 ready write ignored", rd, 0);
    bus_write(4'h8, 32'hFFFF_FFFD);
    bus_read(4'h8, rd);  check("R5 reserved ignored", rd, 0);

    // R6: unmapped offsets
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'h8, rd);  check("R6 unmapped writes no effect", rd, 0);
    bus_read(4'h0, rd);  check("R6 read 0x0", rd, 0);
    bus_read(4'h4, rd);  check("R6 read 0x4", rd, 0);
    bus_read(4'hC, rd);  check("R6 read 0xC", rd, 0);

    // R7: divider ticks
    wait_tick();
    for (int i = 0; i < 3; i++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!tb_tick);
      check("R7 tick spacing", n, DIV);
    end
    cnt = 0;
    for (int i = 0; i < 5 * DIV; i++) begin
      @(negedge clk);
      if (tb_tick) cnt++;
    end
    check("R7 tick count, lf ignored", cnt, 5);

    // R2 + R3: enable then ready exactly SETTLE cycles later
    @(negedge clk);
    bus_addr = 4'h8; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    bus_read(4'h8, rd);  check("R2 enable set, R5 upper zero", rd, 32'h2);
    check("R2 osc_en", {31'b0, osc_en}, 1);
    for (int k = 1; k <= int'(SETTLE); k++) begin
      @(negedge clk);
      bus_read(4'h8, rd);
      check($sformatf("R3 ready at cycle %0d", k), rd,
            (k == int'(SETTLE)) ? 32'h3 : 32'h2);
    end

    // R2/R4: write 0 does not clear
    bus_write(4'h8, 32'h0);
    bus_read(4'h8, rd);  check("R2 zero write keeps bits", rd, 32'h3);
    check("R8 is_lf", {31'b0, tb_is_lf}, 1);

    // R9: passes while ready
    sleep_req = 1'b1; #0.5;
    check("R9 sleep passes", {31'b0, sleep_off}, 1);
    sleep_req = 1'b0; #0.5;
    check("R9 sleep follows low", {31'b0, sleep_off}, 0);

    // R8: one tick per lf rising edge over 10 lf periods
    lf_last = lf_clk;
    do begin @(negedge clk); falls = (lf_last && !lf_clk) ? 1 : 0; lf_last = lf_clk; end
    while (falls == 0);
    cnt = 0; falls = 0;
    while (falls < 10) begin
      @(negedge clk);
      if (tb_tick) cnt++;
      if (lf_last && !lf_clk) falls++;
      lf_last = lf_clk;
    end
    check("R8 lf tick count", cnt, 10);

    // R4: hardware reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    bus_read(4'h8, rd);  check("R4 cleared in reset", rd, 0);
    check("R4 is_lf cleared", {31'b0, tb_is_lf}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(4'h8, rd);  check("R4 cleared after reset", rd, 0);
    wait_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (!tb_tick);
    check("R7 divider after reset", n, DIV);

    // R10: read data follows address in the same cycle
    bus_write(4'h8, 32'h2);
    bus_read(4'h8, rd);  check("R10 read at 0x8", rd, 32'h2);
    bus_read(4'h4, rd);  check("R10 read at 0x4 same cycle", rd, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule